// File: doc/BRIEF.md
# Quad Two-Source Selecting Hold Register

This block holds a group of bit lanes (four by default) that share one set of controls. Each lane has two data inputs. A two-bit select code picks what each lane passes: the first input, the second input, the OR of both, or a constant zero. The result goes into a per-lane storage element. Each lane drives a true output and its inverse.

The storage element is built for a clocked fabric. It loads on a clock edge only while both active-low enable inputs are low, which is the clocked form of a transparent latch. If either enable is high, the stored value is frozen, and the held value is the one captured at the last edge where both enables were low. A synchronous active-high reset clears every lane and takes priority over the enables, the select code and the data.

When both select bits are driven from one wire, the block is a plain two-way selector: both low picks the first input and both high picks the second.

Top module: `quad_sel_hold`

## Requirements
- R1: With `rst` high at a rising clock edge, every bit of `q` is 0 and every bit of `q_n` is 1 after that edge, whatever the enables, select and data are.
- R2: Select code `sel` = 2'b00 with both enables low loads each lane's `d_first` bit, visible after the edge.
- R3: Select code `sel` = 2'b10 (bit 1 set, bit 0 clear) with both enables low loads the OR of each lane's `d_first` and `d_second` bits.
- R4: Select code `sel` = 2'b01 (bit 1 clear, bit 0 set) with both enables low loads 0 into every lane, whatever the data.
- R5: Select code `sel` = 2'b11 with both enables low loads each lane's `d_second` bit.
- R6: With `hold_a_n` high at an edge, `q` keeps its previous value whatever the data and select do.
- R7: With `hold_b_n` high and `hold_a_n` low, the hold behaves exactly as in R6. The held value is the one loaded at the last edge where both enables were low.
- R8: `q_n` is the bitwise inverse of `q` on every cycle after the first clock edge, during reset included.
- R9: If reset is released while an enable is high, `q` stays 0 until the first edge where both enables are low.
- R10: Each lane's output depends only on that lane's own `d_first` and `d_second` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_a_n | input | 1 | Active-low enable A; high freezes the outputs |
| hold_b_n | input | 1 | Active-low enable B; high freezes the outputs |
| sel | input | 2 | Per-lane function code: 00 first, 01 zero, 10 OR, 11 second |
| d_first | input | LANES (4) | First data input, one bit per lane |
| d_second | input | LANES (4) | Second data input, one bit per lane |
| q | output | LANES (4) | Registered true output per lane |
| q_n | output | LANES (4) | Registered inverse output per lane |

## Verification
The bench changes data and select while one enable is high. A design that decoded only one enable, or that loaded while frozen, would let `q` follow the new data. It also releases reset while frozen and then changes the data. A design that reloaded at reset release would show nonzero outputs before the enables open. Lane patterns with differing bits, applied under all four codes, expose swapped codes, such as OR confused with zero, or a lane wired to its neighbour's data. Every cycle, `q_n` is compared against the inverse of the model, so a mirror register that misses the reset shows up.

// File: rtl/quad_sel_hold_pkg.sv
package quad_sel_hold_pkg;

  typedef enum logic [1:0] {
    FN_FIRST  = 2'b00,
    FN_ZERO   = 2'b01,
    FN_EITHER = 2'b10,
    FN_SECOND = 2'b11
  } lane_fn_t;

  function automatic logic lane_eval(input lane_fn_t fn, input logic a, input logic b);
    logic r;
    case (fn)
      FN_FIRST:  r = a;
      FN_ZERO:   r = 1'b0;
      FN_EITHER: r = a | b;
      FN_SECOND: r = b;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qsh_gate.sv
module qsh_gate (
  input  logic       hold_a_n,
  input  logic       hold_b_n,
  input  logic [1:0] sel,
  output logic       open_o,
  output quad_sel_hold_pkg::lane_fn_t fn_o
);
  import quad_sel_hold_pkg::*;

  always_comb begin
    open_o = ~hold_a_n & ~hold_b_n;
    fn_o   = lane_fn_t'(sel);
  end
endmodule

// File: rtl/qsh_lane.sv
module qsh_lane (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  quad_sel_hold_pkg::lane_fn_t fn_i,
  input  logic a_i,
  input  logic b_i,
  output logic q_o,
  output logic qn_o
);
  import quad_sel_hold_pkg::*;

  logic nxt;

  always_comb begin
    nxt = lane_eval(fn_i, a_i, b_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o  <= 1'b0;
      qn_o <= 1'b1;
    end else if (open_i) begin
      q_o  <= nxt;
      qn_o <= ~nxt;
    end
  end
endmodule

// File: rtl/quad_sel_hold.sv
module quad_sel_hold #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_a_n,
  input  logic             hold_b_n,
  input  logic [1:0]       sel,
  input  logic [LANES-1:0] d_first,
  input  logic [LANES-1:0] d_second,
  output logic [LANES-1:0] q,
  output logic [LANES-1:0] q_n
);
  import quad_sel_hold_pkg::*;

  logic     open_w;
  lane_fn_t fn_w;

  qsh_gate u_gate (
    .hold_a_n (hold_a_n),
    .hold_b_n (hold_b_n),
    .sel      (sel),
    .open_o   (open_w),
    .fn_o     (fn_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qsh_lane u_lane (
      .clk    (clk),
      .rst    (rst),
      .open_i (open_w),
      .fn_i   (fn_w),
      .a_i    (d_first[g]),
      .b_i    (d_second[g]),
      .q_o    (q[g]),
      .qn_o   (q_n[g])
    );
  end
endmodule

// File: rtl/quad_sel_hold_chk.sv
module quad_sel_hold_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hold_a_n,
  input logic             hold_b_n,
  input logic [1:0]       sel,
  input logic [LANES-1:0] d_first,
  input logic [LANES-1:0] d_second,
  input logic [LANES-1:0] q,
  input logic [LANES-1:0] q_n
);
  logic open_c;
  assign open_c = ~hold_a_n & ~hold_b_n;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0 && q_n == '1));

  // R2
  pass_first_chk: assert property (@(posedge clk) disable iff (rst)
    (open_c && sel == 2'b00) |=> q == $past(d_first));

  // R3
  pass_or_chk: assert property (@(posedge clk) disable iff (rst)
    (open_c && sel == 2'b10) |=> q == ($past(d_first) | $past(d_second)));

  // R4
  force_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (open_c && sel == 2'b01) |=> q == '0);

  // R5
  pass_second_chk: assert property (@(posedge clk) disable iff (rst)
    (open_c && sel == 2'b11) |=> q == $past(d_second));

  // R6 R7
  frozen_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_a_n || hold_b_n) |=> $stable(q));

  // R8
  inverse_pair_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_n == ~q));
endmodule

bind quad_sel_hold quad_sel_hold_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .hold_a_n(hold_a_n), .hold_b_n(hold_b_n), .sel(sel),
  .d_first(d_first), .d_second(d_second), .q(q), .q_n(q_n)
);

// File: tb/test_quad_sel_hold.sv
module test_quad_sel_hold;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hold_a_n = 1'b0;
  logic             hold_b_n = 1'b0;
  logic [1:0]       sel = 2'b00;
  logic [LANES-1:0] d_first = '0;
  logic [LANES-1:0] d_second = '0;
  logic [LANES-1:0] q;
  logic [LANES-1:0] q_n;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;

  int    mdl [LANES];
  bit    zero_wait = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_sel_hold #(.LANES(LANES)) i_quad_sel_hold (
    .clk(clk), .rst(rst), .hold_a_n(hold_a_n), .hold_b_n(hold_b_n), .sel(sel),
    .d_first(d_first), .d_second(d_second), .q(q), .q_n(q_n)
  );

  // Behavioural reference, one lane at a time
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < LANES; i++) mdl[i] = 0;
      zero_wait = (hold_a_n || hold_b_n);
      tag = "R1";
    end else if (hold_a_n) begin
      tag = zero_wait ? "R9" : "R6";
    end else if (hold_b_n) begin
      tag = zero_wait ? "R9" : "R7";
    end else begin
      zero_wait = 0;
      for (int i = 0; i < LANES; i++) begin
        int a, b;
        a = d_first[i];
        b = d_second[i];
        if (sel == 2'b00) mdl[i] = a;
        else if (sel == 2'b01) mdl[i] = 0;
        else if (sel == 2'b10) mdl[i] = (a + b > 0) ? 1 : 0;
        else mdl[i] = b;
      end
      case (sel)
        2'b00: tag = "R2";
        2'b01: tag = "R4";
        2'b10: tag = "R3";
        default: tag = "R5";
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [LANES-1:0] exp_q;
      for (int i = 0; i < LANES; i++) exp_q[i] = (mdl[i] != 0);
      checks++;
      if (q !== exp_q) begin
        fails++;
        $display("FAIL %s (R10 lanes): q=%b expected %b", tag, q, exp_q);
      end
      checks++;
      if (q_n !== ~exp_q) begin
        fails++;
        $display("FAIL R8: q_n=%b expected %b", q_n, ~exp_q);
      end
    end
  end

  task automatic step(input logic r, input logic ea, input logic eb,
                      input logic [1:0] s, input logic [LANES-1:0] a,
                      input logic [LANES-1:0] b);
    @(negedge clk);
    #1;
    rst = r; hold_a_n = ea; hold_b_n = eb; sel = s; d_first = a; d_second = b;
  endtask

  initial begin
    fork
      begin
        // R1 reset state with busy inputs
        step(1, 0, 0, 2'b11, 4'hF, 4'hF);
        step(1, 0, 0, 2'b10, 4'hA, 4'h5);
        // R2 R3 R4 R5 under distinct lane patterns (R10)
        for (int p = 0; p < 4; p++) begin
          logic [LANES-1:0] a, b;
          a = (p == 0) ? 4'b1010 : (p == 1) ? 4'b0110 : (p == 2) ? 4'b1100 : 4'b0001;
          b = (p == 0) ? 4'b0101 : (p == 1) ? 4'b0011 : (p == 2) ? 4'b1000 : 4'b1110;
          step(0, 0, 0, 2'b00, a, b);
          step(0, 0, 0, 2'b10, a, b);
          step(0, 0, 0, 2'b01, a, b);
          step(0, 0, 0, 2'b11, a, b);
        end
        // tied selects
        step(0, 0, 0, 2'b00, 4'b1001, 4'b0110);
        step(0, 0, 0, 2'b11, 4'b1001, 4'b0110);
        // R6 hold via A, data churns
        step(0, 0, 0, 2'b00, 4'b1011, 4'b0000);
        step(0, 1, 0, 2'b11, 4'b0100, 4'b0100);
        step(0, 1, 0, 2'b01, 4'b0000, 4'b1111);
        step(0, 1, 1, 2'b10, 4'b1111, 4'b1111);
        // R7 hold via B, data churns
        step(0, 0, 0, 2'b11, 4'b0000, 4'b0110);
        step(0, 0, 1, 2'b00, 4'b1001, 4'b1001);
        step(0, 0, 1, 2'b10, 4'b1111, 4'b1111);
        // reset overrides a hold, then R9 release while frozen
        step(1, 1, 0, 2'b11, 4'b1111, 4'b1111);
        step(0, 1, 0, 2'b11, 4'b1111, 4'b1111);
        step(0, 0, 1, 2'b00, 4'b1111, 4'b1111);
        step(0, 0, 0, 2'b00, 4'b1111, 4'b1111);
        step(0, 0, 0, 2'b00, 4'b0000, 4'b0000);
        // mixed sweep
        for (int k = 0; k < 300; k++) begin
          int r;
          r = $urandom_range(0, 99);
          step(r < 4, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
               2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
               4'($urandom_range(0, 15)));
        end
        step(0, 0, 0, 2'b00, 4'b0000, 4'b0000);
        @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run expired, actual hung expected done");
      end
    join_any
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule